// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller with Rotating Priority

This block gathers 64 raw interrupt lines and presents them to a processor as one interrupt request plus the number of the source being served. Each source has a configuration byte holding an enable bit and a two-bit trigger field. The trigger selects active-high level, rising edge or falling edge sensing. There is no active-low level setting. Edge events are captured in two 32-bit status words, and software clears a captured event by writing a one to its bit.

An arbiter picks one pending, enabled source and holds it until that source stops pending. A source stops pending when software clears its status bit (edge sources) or masks it (level sources). The arbiter search starts either at source 0 (fixed priority) or just past the source served last (rotating priority). A control bit selects between the two.

The arbiter is a three-state machine: `ARB_IDLE`, `ARB_GRANT` and `ARB_RETIRE`.
- `ARB_IDLE` moves to `ARB_GRANT` ("pick") when any source is pending, and latches the search winner.
- `ARB_GRANT` moves to `ARB_RETIRE` ("acknowledge") when the held source is no longer pending; otherwise it stays ("hold").
- `ARB_RETIRE` always moves back to `ARB_IDLE` ("rotate"). On this move it sets the search start to the retired source plus one (wrapping 63 to 0) when rotation is on, or to 0 when it is off.

Software reaches the registers through a synchronous bus. `bus_addr` is a word index (byte offset divided by four), `bus_be` holds the byte-lane enables, and read data appears on `bus_rdata` one clock after `bus_rd`.

Top module: `irq_hub`

## Requirements
- R1: After reset every configuration byte reads zero (disabled, level-high), both status words read zero for low inputs, rotation is off, `irq_o` is low, and the index output is 63 with `irq_id_valid_o` low.
- R2: The configuration byte of source n sits at byte offset 0x40+n (word index 0x10+n/4, byte lane n mod 4). Bit 3 is the enable and bits 5:4 the trigger field. The other bits are not stored and read zero, and a byte write leaves the other lanes unchanged.
- R3: Trigger value 0 is active-high level. The source's status bit reads the input as sampled one clock earlier, whether the source is enabled or not.
- R4: Trigger value 1 latches a status bit on a rising input, value 2 on a falling input, and value 3 behaves as rising. A latched bit is set whether or not the source is enabled.
- R5: Status word 0x80 (word index 0x20) holds sources 0–31 and word 0x84 (word index 0x21) holds sources 32–63, source n at bit n mod 32. Writing 1 to a latched edge bit clears it, writing 0 leaves it set, and a new edge in the same clock wins over the clear.
- R6: `irq_o` is high exactly when at least one enabled source has its status bit set.
- R7: While a source is granted, `irq_id_o` shows its number and `irq_id_valid_o` is high; the grant does not move while that source stays pending. With nothing granted, the index is 63 and valid is low. The index register at byte offset 0x28 returns the number in bits 5:0 and valid in bit 8.
- R8: With rotation off, the lowest-numbered pending enabled source is granted.
- R9: Bit 6 of the word at byte offset 0x20 turns on rotation, and it reads back there. With rotation on, the search after an acknowledge starts at the source just past the one retired, so the retired source becomes the lowest priority.
- R10: The word at byte offset 0x24 accepts writes, has no effect, and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| irq_src_i | input | 64 | Raw interrupt inputs |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_id_o | output | 6 | Number of the granted source, 63 when none |
| irq_id_valid_o | output | 1 | High while a source is granted |

## Verification
A table drives one source at a time through every trigger setting, enabled and disabled, with both a low-to-high and a high-to-low input step. This shows which settings latch which transition, that level status follows the pin, and that the enable gates only the request and not the status capture.

Directed sequences then raise three level sources together and mask them one by one, once with rotation off and once with it on. The two runs are built so that the final grant differs: source 2 under fixed priority and source 9 under rotation. A grant that failed to hold, or a rotation pointer that failed to move, would give a different number.

Separate steps cover partial byte writes, status write-zero and write-one, the high status word, and the inert word.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    // Trigger field of a source configuration byte
    typedef enum logic [1:0] {
        TRG_LVL   = 2'd0,
        TRG_RISE  = 2'd1,
        TRG_FALL  = 2'd2,
        TRG_RISE2 = 2'd3
    } trig_e;

    // Arbiter states
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_GRANT  = 2'd1,
        ARB_RETIRE = 2'd2
    } arb_state_e;

    // Register word indices (byte offset / 4)
    localparam logic [5:0] WA_PRIO    = 6'h08;
    localparam logic [5:0] WA_RSVD    = 6'h09;
    localparam logic [5:0] WA_INDEX   = 6'h0A;
    localparam logic [5:0] WA_CFG0    = 6'h10;
    localparam logic [5:0] WA_STAT_LO = 6'h20;
    localparam logic [5:0] WA_STAT_HI = 6'h21;

    // Bit positions
    localparam int ROT_BIT   = 6;
    localparam int EN_BIT    = 3;
    localparam int TRG_LSB   = 4;
    localparam int VALID_BIT = 8;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_hub_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  raw_i,
    input  logic  en_i,
    input  trig_e trig_i,
    input  logic  clr_i,
    output logic  stat_o,
    output logic  pend_o
);

    logic raw_q;
    logic prev_q;
    logic edge_q;
    logic rise;
    logic fall;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            raw_q  <= raw_i;
            prev_q <= raw_q;
        end
    end

    assign rise = raw_q & ~prev_q;
    assign fall = ~raw_q & prev_q;

    always_comb begin
        unique case (trig_i)
            TRG_LVL:   hit = 1'b0;
            TRG_FALL:  hit = fall;
            TRG_RISE:  hit = rise;
            TRG_RISE2: hit = rise;
            default:   hit = 1'b0;
        endcase
    end

    // Edge latch: a new event wins over a clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else if (trig_i == TRG_LVL) begin
            edge_q <= 1'b0;
        end else if (hit) begin
            edge_q <= 1'b1;
        end else if (clr_i) begin
            edge_q <= 1'b0;
        end
    end

    assign stat_o = (trig_i == TRG_LVL) ? raw_q : edge_q;
    assign pend_o = en_i & stat_o;

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == TRG_RISE && raw_q && !prev_q) |=> edge_q); // R4

    AST_EDGE_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q && !clr_i && trig_i != TRG_LVL) |=> edge_q); // R5

endmodule

// File: rtl/irq_rr_arbiter.sv
module irq_rr_arbiter
    import irq_hub_pkg::*;
#(
    parameter  int NSRC = 64,
    localparam int IDW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_i,
    input  logic            rot_en_i,
    output logic [IDW-1:0]  id_o,
    output logic            valid_o
);

    arb_state_e     state_q;
    arb_state_e     state_d;
    logic [IDW-1:0] cur_q;
    logic [IDW-1:0] ptr_q;
    logic [IDW-1:0] win;
    logic           any;

    // Circular search starting at the priority pointer
    always_comb begin
        int j;
        any = 1'b0;
        win = '0;
        for (int i = 0; i < NSRC; i++) begin
            j = (rot_en_i ? int'(ptr_q) : 0) + i;
            if (j >= NSRC) j = j - NSRC;
            if (!any && pend_i[j]) begin
                any = 1'b1;
                win = IDW'(j);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:   if (any) state_d = ARB_GRANT;
            ARB_GRANT:  if (!pend_i[cur_q]) state_d = ARB_RETIRE;
            ARB_RETIRE: state_d = ARB_IDLE;
            default:    state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            ptr_q <= '0;
        end else begin
            if (state_q == ARB_IDLE && any) cur_q <= win;
            if (state_q == ARB_RETIRE) begin
                if (!rot_en_i)                     ptr_q <= '0;
                else if (cur_q == IDW'(NSRC - 1)) ptr_q <= '0;
                else                               ptr_q <= cur_q + 1'b1;
            end
        end
    end

    always_comb begin
        valid_o = (state_q == ARB_GRANT);
        id_o    = valid_o ? cur_q : '1;
    end

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_GRANT && pend_i[cur_q]) |=> (state_q == ARB_GRANT && $stable(cur_q))); // R7

    AST_RETIRE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_RETIRE) |=> !valid_o); // R9

endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
    import irq_hub_pkg::*;
#(
    parameter  int NSRC = 64,
    localparam int IDW  = $clog2(NSRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [5:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    input  logic [NSRC-1:0]      stat_i,
    input  logic [IDW-1:0]       id_i,
    input  logic                 valid_i,
    output logic [NSRC-1:0]      en_o,
    output logic [NSRC-1:0][1:0] trig_o,
    output logic [NSRC-1:0]      clr_o,
    output logic                 rot_en_o
);

    logic [NSRC-1:0]      en_q;
    logic [NSRC-1:0][1:0] trig_q;
    logic                 rot_q;
    logic [31:0]          rd_mux;
    logic [31:0]          rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            trig_q <= '0;
            rot_q  <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == WA_PRIO && bus_be[0]) rot_q <= bus_wdata[ROT_BIT];
            for (int n = 0; n < NSRC; n++) begin
                if (bus_addr == WA_CFG0 + 6'(n / 4) && bus_be[n % 4]) begin
                    en_q[n]   <= bus_wdata[(n % 4) * 8 + EN_BIT];
                    trig_q[n] <= bus_wdata[(n % 4) * 8 + TRG_LSB +: 2];
                end
            end
        end
    end

    // Write-one-to-clear strobes per source
    always_comb begin
        for (int n = 0; n < NSRC; n++) begin
            clr_o[n] = bus_wr
                     && (bus_addr == ((n < 32) ? WA_STAT_LO : WA_STAT_HI))
                     && bus_be[(n % 32) / 8]
                     && bus_wdata[n % 32];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == WA_PRIO) rd_mux[ROT_BIT] = rot_q;
        if (bus_addr == WA_INDEX) begin
            rd_mux[IDW-1:0]  = id_i;
            rd_mux[VALID_BIT] = valid_i;
        end
        for (int n = 0; n < NSRC; n++) begin
            if (bus_addr == WA_CFG0 + 6'(n / 4))
                rd_mux[(n % 4) * 8 +: 8] = {2'b00, trig_q[n], en_q[n], 3'b000};
            if (bus_addr == ((n < 32) ? WA_STAT_LO : WA_STAT_HI))
                rd_mux[n % 32] = stat_i[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign en_o      = en_q;
    assign trig_o    = trig_q;
    assign rot_en_o  = rot_q;

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == WA_RSVD) |=> bus_rdata == 32'h0); // R10

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter  int NSRC = 64,
    localparam int IDW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    input  logic            bus_rd,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] irq_src_i,
    output logic            irq_o,
    output logic [IDW-1:0]  irq_id_o,
    output logic            irq_id_valid_o
);

    logic [NSRC-1:0]      en;
    logic [NSRC-1:0][1:0] trig;
    logic [NSRC-1:0]      clr;
    logic [NSRC-1:0]      stat;
    logic [NSRC-1:0]      pend;
    logic                 rot_en;

    irq_bus_regs #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .stat_i    (stat),
        .id_i      (irq_id_o),
        .valid_i   (irq_id_valid_o),
        .en_o      (en),
        .trig_o    (trig),
        .clr_o     (clr),
        .rot_en_o  (rot_en)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            irq_src_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (irq_src_i[g]),
                .en_i   (en[g]),
                .trig_i (trig_e'(trig[g])),
                .clr_i  (clr[g]),
                .stat_o (stat[g]),
                .pend_o (pend[g])
            );
        end
    endgenerate

    irq_rr_arbiter #(.NSRC(NSRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .rot_en_i (rot_en),
        .id_o     (irq_id_o),
        .valid_o  (irq_id_valid_o)
    );

    assign irq_o = |pend;

    AST_IRQ_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id_valid_o && pend[irq_id_o]) |-> irq_o); // R6

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {trig[1:0], en, v0, v1, exp_stat, exp_irq}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b00_1_0_1_1_1,  // level enabled, rise
        7'b00_0_0_1_1_0,  // level disabled, rise
        7'b01_1_0_1_1_1,  // rising enabled, rise
        7'b01_1_1_0_0_0,  // rising enabled, fall
        7'b10_1_1_0_1_1,  // falling enabled, fall
        7'b10_1_0_1_0_0,  // falling enabled, rise
        7'b10_0_1_0_1_0,  // falling disabled, fall
        7'b11_1_0_1_1_1,  // value 3 acts as rising
        7'b00_1_1_0_0_0,  // level enabled, fall
        7'b01_0_0_1_1_0   // rising disabled, rise
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_o;
    logic [5:0]  irq_id;
    logic        irq_id_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_hub u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_be         (bus_be),
        .bus_wdata      (bus_wdata),
        .bus_rd         (bus_rd),
        .bus_rdata      (bus_rdata),
        .irq_src_i      (irq_src),
        .irq_o          (irq_o),
        .irq_id_o       (irq_id),
        .irq_id_valid_o (irq_id_valid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_cfg(int n, logic en, logic [1:0] trg);
        logic [7:0] b;
        b = {2'b00, trg, en, 3'b000};
        wr(6'h10 + 6'(n / 4), 4'(1 << (n % 4)), 32'(b) << (8 * (n % 4)));
    endtask

    task automatic clear_all();
        wr(6'h20, 4'hF, 32'hFFFF_FFFF);
        wr(6'h21, 4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic arb_run(bit rot, logic [5:0] exp_last, string tag);
        wr(6'h08, 4'h1, rot ? 32'h40 : 32'h0);
        set_cfg(2, 1'b1, 2'd0);
        set_cfg(5, 1'b1, 2'd0);
        set_cfg(9, 1'b1, 2'd0);
        irq_src[2] = 1'b1; irq_src[5] = 1'b1; irq_src[9] = 1'b1;
        wait_cyc(6);
        chk({tag, " first grant"}, {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b1, 6'd2});
        set_cfg(2, 1'b0, 2'd0);
        wait_cyc(6);
        chk({tag, " after mask 2"}, {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b1, 6'd5});
        set_cfg(2, 1'b1, 2'd0);
        wait_cyc(6);
        chk("R7 grant held", {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b1, 6'd5});
        set_cfg(5, 1'b0, 2'd0);
        wait_cyc(6);
        chk({tag, " after mask 5"}, {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b1, exp_last});
        set_cfg(2, 1'b0, 2'd0);
        set_cfg(9, 1'b0, 2'd0);
        irq_src = '0;
        wait_cyc(6);
        chk("R7 none granted", {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b0, 6'd63});
        chk("R6 irq low after masking", 32'(irq_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 index", {26'd0, irq_id_valid, irq_id}, {26'd0, 1'b0, 6'd63});
        rd(6'h10, d); chk("R1 cfg word", d, 32'h0);
        rd(6'h1F, d); chk("R1 cfg last word", d, 32'h0);
        rd(6'h20, d); chk("R1 status lo", d, 32'h0);
        rd(6'h08, d); chk("R1 prio", d, 32'h0);

        // Table of trigger patterns
        for (int i = 0; i < NVEC; i++) begin
            int src;
            logic [31:0] bitv;
            src = (7 * i + 3) % 64;
            set_cfg(src, VEC[i][4], VEC[i][6:5]);
            irq_src[src] = VEC[i][3];
            wait_cyc(3);
            clear_all();
            irq_src[src] = VEC[i][2];
            wait_cyc(3);
            rd(src < 32 ? 6'h20 : 6'h21, d);
            bitv = 32'(d[src % 32]);
            if (VEC[i][6:5] == 2'd0) chk("R3 level status", bitv, 32'(VEC[i][1]));
            else                     chk("R4 edge status", bitv, 32'(VEC[i][1]));
            chk("R6 irq per vector", 32'(irq_o), 32'(VEC[i][0]));
            set_cfg(src, 1'b0, 2'd0);
            irq_src[src] = 1'b0;
            wait_cyc(2);
            clear_all();
        end

        // R2 byte write with junk bits, other lanes untouched
        wr(6'h11, 4'b0010, 32'h0000_FF00);
        rd(6'h11, d); chk("R2 masked byte", d, 32'h0000_3800);
        set_cfg(5, 1'b0, 2'd0);
        rd(6'h11, d); chk("R2 byte cleared", d, 32'h0);

        // R10 inert word
        wr(6'h09, 4'hF, 32'hFFFF_FFFF);
        rd(6'h09, d); chk("R10 reads zero", d, 32'h0);

        // R5 write-one-to-clear on the high word, source 40 -> bit 8
        set_cfg(40, 1'b1, 2'd1);
        irq_src[40] = 1'b1;
        wait_cyc(3);
        rd(6'h21, d); chk("R5 latched bit 8", d, 32'h0000_0100);
        irq_src[40] = 1'b0;
        wr(6'h21, 4'hF, 32'h0);
        rd(6'h21, d); chk("R5 write zero keeps", d, 32'h0000_0100);
        chk("R6 irq from latched edge", 32'(irq_o), 32'd1);
        wait_cyc(4);
        rd(6'h0A, d); chk("R7 index register", d, 32'h0000_0128);
        wr(6'h21, 4'hF, 32'h0000_0100);
        rd(6'h21, d); chk("R5 write one clears", d, 32'h0);
        chk("R6 irq after clear", 32'(irq_o), 32'd0);
        set_cfg(40, 1'b0, 2'd0);
        wait_cyc(4);

        // R8 fixed priority, then R9 rotating priority
        arb_run(1'b0, 6'd2, "R8");
        arb_run(1'b1, 6'd9, "R9");
        rd(6'h08, d); chk("R9 prio readback", d, 32'h40);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule